// File: doc/BRIEF.md
# Packed SIMD Min/Max Unit

This block is a lane-parallel minimum/maximum execution unit for a 256-bit vector datapath. It carries its own instruction decoder: every cycle in which `in_valid` is high, it takes a 32-bit instruction word and two vector source operands. It recognises two instruction forms. The register form takes its second operand from a vector register. The immediate form takes it from a 5-bit field of the instruction word, extended and copied to every lane.

A minor code inside the word picks three things: the lane width (8, 16, 32 or 64 bits), maximum or minimum, and a signed or unsigned comparison. The result, the destination register index and a valid flag appear on registered outputs one clock after the request. Words the unit does not recognise raise an illegal flag in that cycle instead of a valid result.

Top module: `simd_minmax_unit`

## Requirements
- R1: A word is taken as the register form when bits [31:20] equal 12'h747. The minor code is bits [19:15]. Bits [14:10] name the second source, bits [9:5] the first source (`src_a`) and bits [4:0] the destination index that appears on `out_rd`. The second source value is presented on `src_b`.
- R2: A word is taken as the immediate form when bits [31:20] equal 12'h769. The minor code is bits [19:15]. Bits [14:10] carry a 5-bit immediate that replaces the second operand.
- R3: Minor-code bits [1:0] set the lane width: 00 gives 8 bits (32 lanes), 01 gives 16 bits (16 lanes), 10 gives 32 bits (8 lanes) and 11 gives 64 bits (4 lanes). Lane i occupies bits [i*W +: W] of each operand and of the result.
- R4: Minor-code bit 2 picks the operation. With 0, each result lane is the larger of its two operands. With 1, it is the smaller. Equal operands give that common value.
- R5: Minor-code bit 3 picks the comparison. With 0, lanes compare as two's-complement numbers, so 8'h80 is below 8'h7F. With 1, lanes compare as unsigned numbers.
- R6: In the immediate form, the 5-bit field is sign-extended when the comparison is signed and zero-extended when it is unsigned. It is then truncated to the lane width and compared against every lane. For example, 5'b10000 acts as -16.
- R7: A word with `in_valid` high is illegal when it matches neither prefix or when minor-code bit 4 is 1. In the following cycle `out_illegal` is 1 and `out_valid` is 0.
- R8: An illegal word leaves `out_result` and `out_rd` unchanged.
- R9: A legal word with `in_valid` high gives `out_valid` 1 and the new `out_result`/`out_rd` after exactly one clock edge. A cycle without `in_valid` gives `out_valid` 0 and `out_illegal` 0, and the result holds.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_illegal`.
- R11: In the immediate form, the value on `src_b` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| src_a | input | 256 | First source operand |
| src_b | input | 256 | Second source operand (register form) |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| out_result | output | 256 | Lane-wise min/max result |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Unrecognised instruction word seen |

## Verification
In the immediate form, operand selection and lane comparison act in the same cycle: the extended immediate must win over `src_b`, and its sign treatment must match the comparison chosen. The bench provokes this by driving random data on `src_b` for every immediate-form request. It sweeps all 32 immediate values, including 5'b10000, across all sixteen legal minor codes. A per-lane reference computed in the bench judges each result, using a sign-bit flip for signed comparisons. A second overlap is an illegal word arriving straight after a legal one. The bench judges it by checking that the previous result and destination index are still present while `out_illegal` is raised.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int MAX_LANE_W = 64;
  localparam logic [11:0] PFX_REG = 12'h747;
  localparam logic [11:0] PFX_IMM = 12'h769;

  typedef enum logic [1:0] {
    LW_8  = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_64 = 2'b11
  } lane_w_e;

  typedef struct packed {
    logic                    legal;
    logic                    use_imm;
    logic                    take_min;
    logic                    cmp_signed;
    lane_w_e                 lw;
    logic [4:0]              rd;
    logic [MAX_LANE_W-1:0]   imm_ext;
  } smm_op_t;
endpackage

// File: rtl/smm_decoder.sv
module smm_decoder
  import smm_pkg::*;
(
  input  logic [31:0] word,
  output smm_op_t     op
);
  logic [11:0] pfx;
  logic [4:0]  minor;
  logic [4:0]  imm5;
  logic        is_reg, is_imm;

  always_comb begin
    pfx    = word[31:20];
    minor  = word[19:15];
    imm5   = word[14:10];
    is_reg = (pfx == PFX_REG);
    is_imm = (pfx == PFX_IMM);

    op.legal      = (is_reg || is_imm) && !minor[4];
    op.use_imm    = is_imm;
    op.take_min   = minor[2];
    op.cmp_signed = !minor[3];
    op.lw         = lane_w_e'(minor[1:0]);
    op.rd         = word[4:0];
    if (!minor[3])
      op.imm_ext = {{(MAX_LANE_W-5){imm5[4]}}, imm5};
    else
      op.imm_ext = {{(MAX_LANE_W-5){1'b0}}, imm5};
  end
endmodule

// File: rtl/smm_lane.sv
module smm_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cmp_signed,
  input  logic         take_min,
  output logic [W-1:0] y
);
  logic signed [W:0] xa, xb;
  logic              a_lt_b;

  always_comb begin
    xa     = {cmp_signed & a[W-1], a};
    xb     = {cmp_signed & b[W-1], b};
    a_lt_b = (xa < xb);
    y      = (a_lt_b ^ take_min) ? b : a;
  end
endmodule

// File: rtl/smm_lane_array.sv
module smm_lane_array
  import smm_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  smm_op_t         op,
  output logic [VLEN-1:0] res
);
  localparam int NUM_W = 4;

  logic [VLEN-1:0] res_w [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int W = 8 << g;
    localparam int N = VLEN / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] opb;
      assign opb = op.use_imm ? op.imm_ext[W-1:0] : src_b[i*W +: W];
      smm_lane #(.W(W)) u_lane (
        .a          (src_a[i*W +: W]),
        .b          (opb),
        .cmp_signed (op.cmp_signed),
        .take_min   (op.take_min),
        .y          (res_w[g][i*W +: W])
      );
    end
  end

  always_comb begin
    case (op.lw)
      LW_8:    res = res_w[0];
      LW_16:   res = res_w[1];
      LW_32:   res = res_w[2];
      default: res = res_w[3];
    endcase
  end
endmodule

// File: rtl/simd_minmax_unit.sv
module simd_minmax_unit
  import smm_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic            out_valid,
  output logic [VLEN-1:0] out_result,
  output logic [4:0]      out_rd,
  output logic            out_illegal
);
  smm_op_t         op;
  logic [VLEN-1:0] lane_res;

  smm_decoder u_dec (
    .word (instr),
    .op   (op)
  );

  smm_lane_array #(.VLEN(VLEN)) u_lanes (
    .src_a (src_a),
    .src_b (src_b),
    .op    (op),
    .res   (lane_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid & op.legal;
      out_illegal <= in_valid & !op.legal;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && op.legal) begin
      out_result <= lane_res;
      out_rd     <= op.rd;
    end
  end
endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic            out_valid,
  input logic [VLEN-1:0] out_result,
  input logic [4:0]      out_rd,
  input logic            out_illegal
);
  assert_illegal_excl_R7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_valid);

  assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> ($stable(out_result) && $stable(out_rd)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!out_valid && !out_illegal));

  assert_rd_follows_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rd == $past(instr[4:0])));

  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_illegal));
endmodule

bind simd_minmax_unit smm_checker #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_rd      (out_rd),
  .out_illegal (out_illegal)
);

// File: tb/simd_minmax_unit_test.sv
module simd_minmax_unit_test;
  localparam int VLEN = 256;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [VLEN-1:0] src_a = '0;
  logic [VLEN-1:0] src_b = '0;
  logic            out_valid;
  logic [VLEN-1:0] out_result;
  logic [4:0]      out_rd;
  logic            out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  simd_minmax_unit #(.VLEN(VLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_result(out_result), .out_rd(out_rd), .out_illegal(out_illegal)
  );

  function automatic logic [VLEN-1:0] ref_calc(input logic [31:0] ins,
                                               input logic [VLEN-1:0] a,
                                               input logic [VLEN-1:0] b);
    logic [4:0]      mn;
    int              w;
    logic [63:0]     mask, top, ea, eb, ka, kb, r;
    logic [VLEN-1:0] acc;
    mn   = ins[19:15];
    w    = 8 << mn[1:0];
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    top  = 64'd1 << (w - 1);
    acc  = '0;
    for (int i = 0; i < VLEN / w; i++) begin
      ea = 64'(a >> (i * w)) & mask;
      if (ins[31:20] == 12'h769) begin
        if (!mn[3]) eb = {{59{ins[14]}}, ins[14:10]} & mask;
        else        eb = {59'd0, ins[14:10]};
      end else begin
        eb = 64'(b >> (i * w)) & mask;
      end
      ka = mn[3] ? ea : (ea ^ top);
      kb = mn[3] ? eb : (eb ^ top);
      if (mn[2]) r = (ka < kb) ? ea : eb;
      else       r = (ka > kb) ? ea : eb;
      acc = acc | (VLEN'(r) << (i * w));
    end
    return acc;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [VLEN-1:0] got,
                           input logic [VLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // drive at negedge, result is sampled at the following negedge
  task automatic issue(input logic [31:0] ins, input logic [VLEN-1:0] a,
                       input logic [VLEN-1:0] b);
    in_valid = 1'b1; instr = ins; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_legal(input logic [31:0] ins, input logic [VLEN-1:0] a,
                           input logic [VLEN-1:0] b, input string tag);
    logic [VLEN-1:0] exp;
    exp = ref_calc(ins, a, b);
    issue(ins, a, b);
    check_bit({tag, " R9 valid"}, out_valid, 1'b1);
    check_vec({tag, " R3 R4 R5 result"}, out_result, exp);
    check_bit({tag, " R1 rd"}, out_rd === ins[4:0], 1'b1);
  endtask

  task automatic run_illegal(input logic [31:0] ins, input string tag);
    logic [VLEN-1:0] prev_res;
    logic [4:0]      prev_rd;
    prev_res = out_result;
    prev_rd  = out_rd;
    issue(ins, rnd_vec(), rnd_vec());
    check_bit({tag, " R7 illegal"}, out_illegal, 1'b1);
    check_bit({tag, " R7 valid low"}, out_valid, 1'b0);
    check_vec({tag, " R8 result held"}, out_result, prev_res);
    check_bit({tag, " R8 rd held"}, out_rd === prev_rd, 1'b1);
  endtask

  initial begin
    logic [VLEN-1:0] pa [6];
    logic [VLEN-1:0] pb [6];
    logic [VLEN-1:0] held;
    pa[0] = {32{8'h80}};  pb[0] = {32{8'h7F}};
    pa[1] = rnd_vec();    pb[1] = rnd_vec();
    pa[2] = rnd_vec();    pb[2] = rnd_vec();
    pa[3] = rnd_vec();    pb[3] = pa[3];
    pa[4] = '1;           pb[4] = '0;
    pa[5] = rnd_vec();    pb[5] = {pa[5][VLEN-1:128], rnd_vec()[127:0]};

    repeat (3) @(negedge clk);
    check_bit("R10 reset valid", out_valid, 1'b0);
    check_bit("R10 reset illegal", out_illegal, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // signed byte corner: 0x80 vs 0x7F
    run_legal({12'h747, 5'b00000, 5'd2, 5'd1, 5'd3}, pa[0], pb[0], "R5 smax8");
    check_vec("R5 signed max picks 7F", out_result, {32{8'h7F}});
    run_legal({12'h747, 5'b01000, 5'd2, 5'd1, 5'd3}, pa[0], pb[0], "R5 umax8");
    check_vec("R5 unsigned max picks 80", out_result, {32{8'h80}});

    // register-form sweep over all legal minor codes
    for (int m = 0; m < 16; m++)
      for (int p = 0; p < 6; p++)
        run_legal({12'h747, 5'(m), 5'(p), 5'(p + 1), 5'(m + p)},
                  pa[p], pb[p], "R1 reg");

    // immediate sweep; src_b carries garbage that must not matter
    for (int m = 0; m < 16; m++)
      for (int im = 0; im < 32; im++)
        for (int p = 0; p < 2; p++)
          run_legal({12'h769, 5'(m), 5'(im), 5'd7, 5'(im)},
                    pa[p + 1], rnd_vec(), "R2 R6 R11 imm");

    // immediate -16 against zero lanes, signed min of byte lanes
    run_legal({12'h769, 5'b00100, 5'b10000, 5'd0, 5'd9}, '0, rnd_vec(), "R6 imm-16");
    check_vec("R6 signed min with -16", out_result, {32{8'hF0}});

    // idle cycle
    held = out_result;
    @(negedge clk);
    check_bit("R9 idle valid low", out_valid, 1'b0);
    check_bit("R9 idle illegal low", out_illegal, 1'b0);
    check_vec("R9 idle result held", out_result, held);

    // illegal words right after a legal one
    run_legal({12'h747, 5'b00011, 5'd4, 5'd5, 5'd17}, pa[1], pb[1], "R1 pre");
    run_illegal({12'h747, 5'b10000, 15'h1234}, "R7 reg bit4");
    run_illegal({12'h769, 5'b11011, 15'h0abc}, "R7 imm bit4");
    run_illegal({12'h746, 5'b00000, 15'h0001}, "R7 bad prefix");
    run_illegal(32'h0000_0000, "R7 zero word");

    // reset mid-run
    in_valid = 1'b1; instr = {12'h747, 5'b00001, 15'h0021};
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check_bit("R10 reset wins valid", out_valid, 1'b0);
    check_bit("R10 reset wins illegal", out_illegal, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired, got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule